// File: doc/BRIEF.md
# Saturating FP64-to-int32 vector converter

This block takes a 128-bit vector that holds two IEEE-754 double-precision values and turns each one into a 32-bit integer. A mode input chooses a two's-complement result or an unsigned result. The conversion always truncates toward zero. A value that does not fit the chosen integer range saturates, and a NaN gets a fixed code. Each lane's word is written twice, into the upper and the lower half of that lane's 64-bit doubleword.

Lane 0 is the high doubleword (`in_data[127:64]`) and appears in `out_data[127:64]`. Lane 1 is the low doubleword. Operands enter through a valid/ready handshake. A single output register can be built in with a parameter, or left out so that the path is combinational.

The two modes resolve competing error conditions in different orders. In signed mode a NaN wins over every range check. In unsigned mode a negative sign wins over every other check, so a NaN with its sign bit set gives zero.

Top module: `fws_cvt`

## Requirements
- R1: In signed mode (`in_unsigned`=0), an in-range lane gives its value truncated toward zero as a two's-complement word. For example, 2.5 gives 2, -2.5 gives 0xFFFFFFFE, and 2147483647.0 gives 0x7FFFFFFF.
- R2: In signed mode, a NaN lane gives 0x80000000 whatever its sign. A NaN is exponent field bits 62:52 all ones with fraction bits 51:0 nonzero. This code wins over the range checks.
- R3: In signed mode, a lane whose value is 2^31 or more, including +infinity, gives 0x7FFFFFFF. A lane whose value is below -2^31, including -infinity, gives 0x80000000.
- R4: In unsigned mode (`in_unsigned`=1), a lane with sign bit 63 set and any other bit set gives 0. This covers negative fractions, -infinity and NaNs with the sign bit set. Negative zero also gives 0.
- R5: In unsigned mode, a positive NaN gives 0x80000000. A non-NaN value of 2^32 or more, including +infinity, gives 0xFFFFFFFF.
- R6: In unsigned mode, a value from 0 to below 2^32 gives its truncated value. For example, 4294967295.0 gives 0xFFFFFFFF and 3000000000.5 gives 0xB2D05E00.
- R7: The word of lane 0 (`in_data[127:64]`) fills both `out_data[127:96]` and `out_data[95:64]`. The word of lane 1 (`in_data[63:0]`) fills both `out_data[63:32]` and `out_data[31:0]`.
- R8: With `PIPE`=1, `out_valid` is high in the cycle after an accepted input. The output is held unchanged while `out_ready` is low. `in_ready` is high whenever the output is empty or being taken.
- R9: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R10: Magnitudes below 1.0 give 0 in both modes without saturating. This includes denormals and zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand vector offered |
| in_ready | output | 1 | Block can take an operand vector |
| in_data | input | 128 | Two FP64 lanes; lane 0 in bits 127:64 |
| in_unsigned | input | 1 | 1 selects unsigned result, 0 signed |
| out_valid | output | 1 | Result vector offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Each lane word duplicated in its doubleword |

## Verification
The hardest cases to reach are the ones where two error conditions overlap, because their outcome depends on the mode's priority. Examples are a NaN with its sign bit set, an infinity whose exponent matches the NaN exponent, and values exactly at ±2^31 and 2^32-1. The stimulus builds these bit patterns directly and sends each one under both modes, so each lane goes through a different branch of the priority chain. A second phase sends pseudo-random reals spread across the saturation points while `out_ready` stalls every third cycle, which exercises the hold path.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int BIAS   = 1023;
  localparam int INT_W  = 32;
  localparam int SH_W   = $clog2(INT_W);

  typedef struct packed {
    logic             sgn;
    logic             nan;
    logic             nonzero;
    logic             big;
    logic [INT_W-1:0] mag;
  } lane_cls_t;
endpackage

// File: rtl/fws_lane_cls.sv
module fws_lane_cls
  import fws_pkg::*;
(
  input  logic [FP_W-1:0] x,
  output lane_cls_t       cls
);
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [FRAC_W:0]   mant;
  logic [SH_W-1:0]   sh;

  assign ex   = x[FP_W-2 -: EXP_W];
  assign fr   = x[FRAC_W-1:0];
  assign mant = {1'b1, fr};
  assign sh   = SH_W'(ex - EXP_W'(BIAS));

  always_comb begin
    cls.sgn     = x[FP_W-1];
    cls.nan     = (&ex) & (|fr);
    cls.nonzero = |x[FP_W-2:0];
    cls.big     = 1'b0;
    cls.mag     = '0;
    if (ex >= EXP_W'(BIAS + INT_W)) begin
      cls.big = 1'b1;
    end else if (ex >= EXP_W'(BIAS)) begin
      cls.mag = INT_W'(mant >> (FRAC_W - int'(sh)));
    end
  end
endmodule

// File: rtl/fws_lane_sel.sv
module fws_lane_sel
  import fws_pkg::*;
(
  input  lane_cls_t        cls,
  input  logic             uns,
  output logic [INT_W-1:0] word
);
  localparam logic [INT_W-1:0] MIN_S = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_S = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MAX_U = '1;
  localparam logic [INT_W-1:0] NAN_W = MIN_S;

  logic             s_hi, s_lo, u_neg, u_hi;
  logic             err;
  logic [INT_W-1:0] trunc, sat, mask;

  assign s_hi  = ~cls.sgn & (cls.big | cls.mag[INT_W-1]);
  assign s_lo  =  cls.sgn & (cls.big | (cls.mag > MIN_S));
  assign u_neg =  cls.sgn & cls.nonzero;
  assign u_hi  = ~cls.sgn & cls.big;

  always_comb begin
    if (uns) begin
      trunc = cls.mag;
      err   = u_neg | cls.nan | u_hi;
      if (u_neg)        sat = '0;
      else if (cls.nan) sat = NAN_W;
      else              sat = MAX_U;
    end else begin
      trunc = cls.sgn ? (~cls.mag + 1'b1) : cls.mag;
      err   = cls.nan | s_hi | s_lo;
      if (cls.nan)      sat = NAN_W;
      else if (s_hi)    sat = MAX_S;
      else              sat = MIN_S;
    end
    mask = {INT_W{err}};
    word = (trunc & ~mask) | (sat & mask);
  end
endmodule

// File: rtl/fws_stage.sv
module fws_stage #(
  parameter int DW   = 128,
  parameter int PIPE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  generate
    if (PIPE != 0) begin : g_reg
      logic          vld_q, vld_d, load;
      logic [DW-1:0] dat_q;

      assign in_ready = ~vld_q | out_ready;
      assign load     = in_valid & in_ready;

      always_comb begin
        vld_d = vld_q;
        if (load)           vld_d = 1'b1;
        else if (out_ready) vld_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
      end

      always_ff @(posedge clk) begin
        if (load) dat_q <= in_data;
      end

      assign out_valid = vld_q;
      assign out_data  = dat_q;
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/fws_cvt.sv
module fws_cvt
  import fws_pkg::*;
#(
  parameter int LANES = 2,
  parameter int PIPE  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [FP_W*LANES-1:0] in_data,
  input  logic                  in_unsigned,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [FP_W*LANES-1:0] out_data
);
  localparam int DW = FP_W * LANES;

  logic [DW-1:0] res;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_cls_t        cls;
      logic [INT_W-1:0] word;

      fws_lane_cls u_cls (
        .x   (in_data[FP_W*(LANES-i)-1 -: FP_W]),
        .cls (cls)
      );

      fws_lane_sel u_sel (
        .cls  (cls),
        .uns  (in_unsigned),
        .word (word)
      );

      assign res[FP_W*(LANES-i)-1 -: FP_W] = {word, word};
    end
  endgenerate

  fws_stage #(.DW(DW), .PIPE(PIPE)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/fws_chk.sv
module fws_chk #(
  parameter int LANES = 2,
  parameter int PIPE  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [63:0]      in_lane0,
  input logic             in_unsigned,
  input logic             out_valid,
  input logic             out_ready,
  input logic [64*LANES-1:0] out_data
);
  logic        acc, l0_nan, l0_neg;
  logic [31:0] l0_word;

  assign acc     = in_valid & in_ready;
  assign l0_nan  = (&in_lane0[62:52]) & (|in_lane0[51:0]);
  assign l0_neg  = in_lane0[63] & (|in_lane0[62:0]);
  assign l0_word = out_data[64*LANES-1 -: 32];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_dup
      // R7
      halves_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[64*i+63 -: 32] == out_data[64*i+31 -: 32]));
    end

    if (PIPE != 0) begin : g_seq
      // R8
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      // R8
      accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);
      // R2
      nan_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_unsigned && l0_nan) |=> (l0_word == 32'h8000_0000));
      // R4
      neg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_unsigned && l0_neg) |=> (l0_word == 32'h0));
    end else begin : g_comb
      // R2
      nan_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_unsigned && l0_nan) |-> (l0_word == 32'h8000_0000));
      // R4
      neg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_unsigned && l0_neg) |-> (l0_word == 32'h0));
    end
  endgenerate
endmodule

bind fws_cvt fws_chk #(.LANES(LANES), .PIPE(PIPE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_lane0    (in_data[64*LANES-1 -: 64]),
  .in_unsigned (in_unsigned),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/fws_cvt_bench.sv
module fws_cvt_bench;
  localparam int DW = 128;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, in_valid, in_ready, in_unsigned, out_valid, out_ready;
  logic [DW-1:0] in_data, out_data;

  fws_cvt #(.LANES(2), .PIPE(1)) u_fws_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_unsigned(in_unsigned), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct { logic [DW-1:0] d; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit stall_en = 0;
  int cyc = 0;

  function automatic logic [31:0] model(input logic [63:0] b, input bit uns);
    real v;
    bit  nan;
    v   = $bitstoreal(b);
    nan = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    if (!uns) begin
      if (nan)                     return 32'h8000_0000;
      if (v >= 2147483648.0)       return 32'h7FFF_FFFF;
      if (v < -2147483648.0)       return 32'h8000_0000;
      return $rtoi(v);
    end
    if (b[63] && b[62:0] != 0)     return 32'h0;
    if (nan)                       return 32'h8000_0000;
    if (v >= 4294967296.0)         return 32'hFFFF_FFFF;
    if (v >= 2147483648.0)         return $rtoi(v - 2147483648.0) + 32'h8000_0000;
    return $rtoi(v);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b,
                      input bit uns, input string tag);
    exp_t e;
    logic [31:0] wa, wb;
    in_data = {a, b};
    in_unsigned = uns;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    wa = model(a, uns);
    wb = model(b, uns);
    e.d = {wa, wa, wb, wb};
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R8", "latency out_valid", {127'b0, out_valid}, 128'd1);
  endtask

  // output ready pattern
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      out_ready = !stall_en || (cyc % 3 != 0);
    end
  end

  // monitor
  bit            held_v = 0;
  logic [DW-1:0] held_d;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (held_v)
        check(out_valid === 1'b1 && out_data === held_d, "R8", "hold while stalled",
              out_data, held_d);
      held_v = 0;
      if (out_valid === 1'b1) begin
        if (out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R8", "unexpected output", out_data, '0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_data === e.d, e.tag, "result", out_data, e.d);
          end
        end else begin
          held_v = 1;
          held_d = out_data;
        end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_unsigned = 1'b0;
    in_data = '0;
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    check(out_valid === 1'b0, "R9", "out_valid in reset", {127'b0, out_valid}, 128'd0);
    check(in_ready === 1'b1, "R9", "in_ready in reset", {127'b0, in_ready}, 128'd1);
    rst_n = 1'b1;
    @(posedge clk);
    #2;

    // R1 signed truncation, R7 distinct lanes
    send($realtobits(2.5), $realtobits(-2.5), 0, "R1");
    send($realtobits(123456789.75), $realtobits(-98765.999), 0, "R7");
    send(64'h41DF_FFFF_FFC0_0000, 64'hC1E0_0000_0000_0000, 0, "R1");
    // R3 saturation and infinities
    send(64'h41E0_0000_0000_0000, 64'hC1E0_0000_0020_0000, 0, "R3");
    send(64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 0, "R3");
    send($realtobits(1.0e20), $realtobits(-1.0e20), 0, "R3");
    // R2 NaN in signed mode, either sign
    send(64'hFFF8_0000_0000_0000, 64'h7FF0_0000_0000_0001, 0, "R2");
    // R10 small magnitudes
    send($realtobits(0.75), 64'h0000_0000_0000_0001, 0, "R10");
    send(64'h8000_0000_0000_0000, $realtobits(-0.999), 0, "R10");
    // R4 unsigned negative priority
    send($realtobits(-0.5), 64'hFFF8_0000_0000_0000, 1, "R4");
    send(64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1, "R4");
    send($realtobits(-3.0e9), 64'hFFF0_0000_0000_0001, 1, "R4");
    // R5 unsigned NaN and overflow
    send(64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1, "R5");
    send($realtobits(4294967296.0), $realtobits(1.0e12), 1, "R5");
    // R6 unsigned range
    send($realtobits(4294967295.0), $realtobits(3000000000.5), 1, "R6");
    send($realtobits(2147483648.0), $realtobits(7.9), 1, "R6");
    send(64'h0000_0000_0000_0001, $realtobits(0.3), 1, "R10");

    // R8 stream with stalls
    stall_en = 1;
    lf = 32'hACE1_1234;
    for (int k = 0; k < 40; k++) begin
      real ra, rb;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ra = $itor($signed(lf)) * 1.7;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rb = $itor($signed(lf)) * 0.37;
      send($realtobits(ra), $realtobits(rb), lf[3], "R8");
    end
    stall_en = 0;

    for (int k = 0; k < 200 && sb.size() != 0; k++) @(posedge clk);
    check(sb.size() == 0, "R8", "all results drained", DW'(sb.size()), '0);
    finish_run();
  end
endmodule